// File: doc/BRIEF.md
# Packed Pairwise Add/Subtract Unit

This block reduces neighbouring element pairs inside two wide operands. Each operand is split into signed lanes of 16 or 32 bits. Every result element is the sum or the difference of two adjacent lanes from the same operand. The results from operand A are packed into the low half of the output word, and the results from operand B into the high half. The output word has the same width as one operand.

A 3-bit opcode selects the operation. Bit 0 picks subtract, bit 1 picks 32-bit lanes, and bit 2 picks signed saturation. Saturation takes effect on 16-bit lanes only. The caller pulses `in_vld` along with the operands and the opcode. One clock later the registered result is presented with `res_vld`. When no strobe arrives, the result register keeps its value.

The asynchronous active-low reset clears the valid flag at once. Its release is synchronised to the clock through two flops.

Top module: `hpair_unit`

## Requirements
- R1: With opcode 3'b000 and 16-bit lanes, result element k (k = 0..3, bits [16k+15:16k]) equals the wrapping sum mod 2^16 of operand A lanes 2k and 2k+1, where lane j is bits [16j+15:16j].
- R2: Results from operand B take the upper half of the result. In 16-bit mode, result element 4+k is formed from B lanes 2k and 2k+1. In 32-bit mode, result dwords 2 and 3 are formed from B dwords 0/1 and 2/3.
- R3: With opcode 3'b001, each 16-bit result is lane 2k minus lane 2k+1, wrapping mod 2^16.
- R4: With opcode 3'b100 (saturating add, 16-bit), a sum above 32767 gives 0x7FFF, a sum below -32768 gives 0x8000, and any other sum is exact.
- R5: With opcode 3'b101 (saturating subtract, 16-bit), the difference lane 2k minus lane 2k+1 is clamped to 0x7FFF or 0x8000 in the same way.
- R6: With opcode 3'b010 or 3'b011, dword results are the sum or the difference (dword 2k minus dword 2k+1), wrapping mod 2^32. Dword j is bits [32j+31:32j].
- R7: Setting bit 2 together with bit 1 (opcodes 3'b110 and 3'b111) gives exactly the wrapping 32-bit result of 3'b010 and 3'b011.
- R8: The opcode bits act independently: bit 0 selects subtract, bit 1 selects 32-bit lanes, and bit 2 selects saturation. All eight codes follow this decoding.
- R9: A strobe in cycle N produces `res` and `res_vld`=1 after the clock edge that ends cycle N. Back-to-back strobes give back-to-back results. When there is no strobe, `res_vld` falls to 0 and `res` holds its last value.
- R10: Asserting `rst_n` low clears `res_vld` at once, without waiting for a clock edge. `res_vld` stays 0 until a new strobe arrives after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input strobe, one cycle per operation |
| opa | input | 128 | Operand A, packed lanes |
| opb | input | 128 | Operand B, packed lanes |
| opc | input | 3 | Opcode: bit0 subtract, bit1 32-bit lanes, bit2 saturate |
| res | output | 128 | Registered packed result |
| res_vld | output | 1 | Result valid, one cycle after the strobe |

## Verification
The bench drives 16-bit pairs whose true sum or difference lies just past either signed limit and just inside it. A design that checks overflow on the wrong bit, or clamps to the wrong polarity, would return a wrapped value or a flipped limit. Running 32-bit operands with the saturate bit set catches a design that lets the 16-bit clamp leak into the wide lanes. Asymmetric lane values catch a swapped subtraction order or swapped halves, which would show up as negated differences or as A results landing in the high half. Back-to-back and idle cycles catch a result register that ignores its enable or a valid flag that lingers.

// File: rtl/hpair_pkg.sv
package hpair_pkg;

  // Opcode fields: bit2 saturate, bit1 32-bit lanes, bit0 subtract
  typedef struct packed {
    logic sat;
    logic wide;
    logic sub;
  } hp_op_t;

  localparam int unsigned HP_OP_W = $bits(hp_op_t);

endpackage

// File: rtl/hpair_rst_sync.sv
module hpair_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/hpair_lane.sv
// One pairwise reduction: lo +/- hi, optional signed clamp.
module hpair_lane #(
  parameter int unsigned W      = 16,
  parameter bit          SAT_EN = 1'b1
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic         sub,
  input  logic         sat,
  output logic [W-1:0] r
);

  logic [W:0]   lo_x;
  logic [W:0]   hi_x;
  logic [W:0]   ext;
  logic         ovf;
  logic [W-1:0] clamp;

  always_comb begin
    lo_x  = {lo[W-1], lo};
    hi_x  = {hi[W-1], hi};
    ext   = sub ? (lo_x - hi_x) : (lo_x + hi_x);
    ovf   = ext[W] ^ ext[W-1];
    clamp = {ext[W], {(W-1){~ext[W]}}};
    r     = (SAT_EN && sat && ovf) ? clamp : ext[W-1:0];
  end

endmodule

// File: rtl/hpair_pack.sv
module hpair_pack
  import hpair_pkg::*;
#(
  parameter int unsigned DW = 128
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  hp_op_t        op,
  output logic [DW-1:0] r
);

  localparam int unsigned P16 = DW / 32;  // 16-bit pairs per operand
  localparam int unsigned P32 = DW / 64;  // 32-bit pairs per operand

  logic [1:0][DW-1:0] src;
  logic [DW-1:0]      r16;
  logic [DW-1:0]      r32;

  assign src[0] = a;
  assign src[1] = b;

  for (genvar s = 0; s < 2; s++) begin : g_opnd
    for (genvar p = 0; p < P16; p++) begin : g_p16
      hpair_lane #(.W(16), .SAT_EN(1'b1)) u_l16 (
        .lo  (src[s][32*p +: 16]),
        .hi  (src[s][32*p+16 +: 16]),
        .sub (op.sub),
        .sat (op.sat),
        .r   (r16[(s*P16+p)*16 +: 16])
      );
    end
    for (genvar p = 0; p < P32; p++) begin : g_p32
      hpair_lane #(.W(32), .SAT_EN(1'b0)) u_l32 (
        .lo  (src[s][64*p +: 32]),
        .hi  (src[s][64*p+32 +: 32]),
        .sub (op.sub),
        .sat (op.sat),
        .r   (r32[(s*P32+p)*32 +: 32])
      );
    end
  end

  assign r = op.wide ? r32 : r16;

endmodule

// File: rtl/hpair_unit.sv
module hpair_unit
  import hpair_pkg::*;
#(
  parameter int unsigned DW = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [DW-1:0]        opa,
  input  logic [DW-1:0]        opb,
  input  logic [HP_OP_W-1:0]   opc,
  output logic [DW-1:0]        res,
  output logic                 res_vld
);

  logic          rst_sync_n;
  hp_op_t        op;
  logic [DW-1:0] pack_r;
  logic [DW-1:0] res_d, res_q;
  logic          vld_d, vld_q;

  hpair_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign op = hp_op_t'(opc);

  hpair_pack #(.DW(DW)) u_pack (
    .a  (opa),
    .b  (opb),
    .op (op),
    .r  (pack_r)
  );

  // next state
  always_comb begin
    vld_d = in_vld;
    res_d = in_vld ? pack_r : res_q;
  end

  // valid flag: reset
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= vld_d;
  end

  // datapath register: enable only
  always_ff @(posedge clk) begin
    res_q <= res_d;
  end

  assign res     = res_q;
  assign res_vld = vld_q;

endmodule

// File: rtl/hpair_unit_chk.sv
module hpair_unit_chk #(
  parameter int unsigned DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic [2:0]    opc,
  input logic [DW-1:0] res,
  input logic          res_vld
);

  p_vld_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> res_vld);

  p_vld_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !res_vld);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(res));

  p_sat_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && opc == 3'b100 && !opa[15] && !opa[31]) |=> !res[15]);

  p_sat_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && opc == 3'b100 && opa[15] && opa[31]) |=> res[15]);

  p_sub_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && opc[1:0] == 2'b01 && opa[15:0] == opa[31:16]) |=> (res[15:0] == 16'h0));

  p_sub_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && opc[1:0] == 2'b11 && opb[31:0] == opb[63:32]) |=> (res[DW/2+31:DW/2] == 32'h0));

endmodule

bind hpair_unit hpair_unit_chk #(.DW(DW)) u_hpair_unit_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .opa     (opa),
  .opb     (opb),
  .opc     (opc),
  .res     (res),
  .res_vld (res_vld)
);

// File: tb/hpair_unit_bench.sv
module hpair_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         in_vld;
  logic [127:0] opa, opb;
  logic [2:0]   opc;
  logic [127:0] res;
  logic         res_vld;

  int n_run;
  int n_fail;

  hpair_unit u_hpair_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opa(opa), .opb(opb),
    .opc(opc), .res(res), .res_vld(res_vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference from the requirement text
  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b, logic [2:0] op);
    logic [127:0] out;
    logic [127:0] s;
    out = '0;
    if (op[1]) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] x, y;
        s = (k < 2) ? a : b;
        x = s[64*(k%2) +: 32];
        y = s[64*(k%2)+32 +: 32];
        out[32*k +: 32] = op[0] ? x - y : x + y;
      end
    end else begin
      for (int k = 0; k < 8; k++) begin
        logic signed [15:0] x, y;
        int v;
        s = (k < 4) ? a : b;
        x = s[32*(k%4) +: 16];
        y = s[32*(k%4)+16 +: 16];
        v = op[0] ? int'(x) - int'(y) : int'(x) + int'(y);
        if (op[2] && v > 32767)  v = 32767;
        if (op[2] && v < -32768) v = -32768;
        out[16*k +: 16] = v[15:0];
      end
    end
    return out;
  endfunction

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one strobe, result checked at the following falling edge
  task automatic send(string req, logic [127:0] a, logic [127:0] b, logic [2:0] op);
    @(negedge clk);
    opa = a; opb = b; opc = op; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    chk(req, {127'h0, res_vld}, 128'h1);
    chk(req, res, model(a, b, op));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 reset", {127'h0, res_vld}, 128'h0);
  endtask

  task automatic t_add16;
    // R1 and R2
    send("R1", 128'h0004_0003_0002_0001_FFFF_0001_1234_1111,
               128'h0, 3'b000);
    send("R2", 128'h0000_0001_0000_0002_0000_0003_0000_0004,
               128'h0010_0020_0030_0040_0050_0060_0070_0080, 3'b000);
    send("R1 wrap", {4{32'h7FFF_0001}}, {4{32'h8000_8000}}, 3'b000);
  endtask

  task automatic t_sub16;
    send("R3", 128'h0001_0005_0009_0003_0000_0000_0003_0001,
               128'h7FFF_8000_0001_8000_1234_5678_0000_0000, 3'b001);
  endtask

  task automatic t_sat_add;
    send("R4 high", {4{32'h2000_7000}}, {4{32'h0001_7FFE}}, 3'b100);
    send("R4 low",  {4{32'hFFFF_8000}}, {4{32'hFFFF_8001}}, 3'b100);
    send("R4 mixed", 128'h8000_7FFF_0001_7FFF_8000_8000_FFFE_0003,
                     128'h1234_4321_C000_C000_4000_4000_7FFF_0000, 3'b100);
  endtask

  task automatic t_sat_sub;
    send("R5 high", {4{32'h8000_0000}}, {4{32'hFFFF_7FFF}}, 3'b101);
    send("R5 low",  {4{32'h0001_8000}}, {4{32'h0001_8001}}, 3'b101);
    send("R5 mixed", 128'h7FFF_8000_8000_7FFF_0005_0003_FFFF_FFFE,
                     128'h0000_0000_0001_0000_8000_7FFE_0002_0001, 3'b101);
  endtask

  task automatic t_wide;
    send("R6 add", 128'h0000_0001_FFFF_FFFF_8000_0000_8000_0000,
                   128'h1111_1111_2222_2222_7FFF_FFFF_0000_0001, 3'b010);
    send("R6 sub", 128'h0000_0005_0000_0003_8000_0000_0000_0001,
                   128'h0000_0000_0000_0000_ABCD_0000_ABCD_0000, 3'b011);
  endtask

  task automatic t_wide_sat;
    logic [127:0] a, b;
    a = 128'h7FFF_FFFF_7FFF_FFFF_8000_0000_FFFF_FFFF;
    b = 128'h0000_0001_7FFF_FFFF_0000_0001_8000_0000;
    send("R7 add", a, b, 3'b110);
    chk("R7 add equals wrap", res, model(a, b, 3'b010));
    send("R7 sub", a, b, 3'b111);
    chk("R7 sub equals wrap", res, model(a, b, 3'b011));
  endtask

  task automatic t_all_codes;
    for (int c = 0; c < 8; c++) begin
      send("R8", 128'h7F00_8100_0123_F00D_9000_9000_7000_1000,
                 128'hDEAD_BEEF_0000_0001_8000_7FFF_4000_4000, 3'(c));
    end
  endtask

  task automatic t_timing;
    logic [127:0] hold;
    @(negedge clk);
    opa = {8{16'h0101}}; opb = {8{16'h0202}}; opc = 3'b000; in_vld = 1'b1;
    @(negedge clk);
    chk("R9 first", res, model({8{16'h0101}}, {8{16'h0202}}, 3'b000));
    opa = {8{16'h0003}}; opb = {8{16'h0001}}; opc = 3'b001;
    @(negedge clk);
    in_vld = 1'b0;
    chk("R9 second", res, model({8{16'h0003}}, {8{16'h0001}}, 3'b001));
    chk("R9 vld", {127'h0, res_vld}, 128'h1);
    hold = res;
    opa = '1; opb = '1; opc = 3'b010;
    @(negedge clk);
    chk("R9 idle vld", {127'h0, res_vld}, 128'h0);
    @(negedge clk);
    chk("R9 hold", res, hold);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    opa = {8{16'h0001}}; opb = '0; opc = 3'b000; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    #1 rst_n = 1'b0;
    #1 chk("R10 async clear", {127'h0, res_vld}, 128'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 stays low", {127'h0, res_vld}, 128'h0);
    send("R10 after reset", {8{16'h0002}}, {8{16'h0003}}, 3'b000);
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; in_vld = 1'b0; opa = '0; opb = '0; opc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_add16();
    t_sub16();
    t_sat_add();
    t_sat_sub();
    t_wide();
    t_wide_sat();
    t_all_codes();
    t_timing();
    t_reset_mid();
    finish_up();
  end

endmodule